// File: doc/BRIEF.md
# Two-Input Grant/Ready Handshake Controller

This block turns two request-style input lines into two handshake outputs. The grant output rises as soon as either request line goes high. The ready output rises once the second request line joins the first. When the first of the two lines drops, grant falls. Ready is then released after the request lines have dropped. A single registered state bit holds the history. Together with the sampled request pair, it fully determines both outputs.

The request lines are sampled on the rising clock edge through a short shift chain, whose depth is set by a parameter. The state bit is updated from the sampled pair. Grant and ready are computed combinationally from the sampled pair and the state bit. The handshake assumes that only one request line changes between stable samples. When a sample shows both lines changing at once, a sticky misuse flag is raised. Only reset clears it.

Top module: `hgr_ctrl`

## Requirements
- R1: While reset is asserted and after its release with both requests low, grant, ready and proto_err are 0 and the state bit is 0.
- R2: A request value reaches the outputs IN_STAGES rising edges after it is applied. Before that edge, the outputs still reflect the older sample.
- R3: Suppose the previous sample had both requests low and the current sample has exactly one request high. Then grant is 1 and ready is 0.
- R4: When the sample has both requests high, grant and ready are both 1.
- R5: Suppose both requests were sampled high and then one of them drops. Then grant is 0 and ready stays 1.
- R6: When both requests are sampled low, ready keeps its value for that cycle. If both stay low on the next sample, ready is 0 from then on.
- R7: If only one request rises and then falls, grant pulses and ready never rises.
- R8: With sampled requests a (bit 1) and b (bit 0) and state s, the outputs follow three equations: grant = (a|b)&~s | a&b, ready = s | a&b, and next s = (a|b)&s | a&b.
- R9: If the value entering the last sampling stage differs from that stage's current value in both bits, proto_err becomes 1 on that edge. It then stays 1 until reset.
- R10: A raised proto_err does not change how grant and ready follow the R8 equations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a | input | 1 | Request line a (sample bit 1) |
| req_b | input | 1 | Request line b (sample bit 0) |
| grant | output | 1 | Grant output |
| ready | output | 1 | Ready output |
| proto_err | output | 1 | Sticky flag for simultaneous change of both requests |

## Verification
The assertions run on every cycle. They cover the outputs after a single rise from idle, after both requests are high, and after one request drops from the both-high state. They also check ready release after two idle samples and the setting and stickiness of the misuse flag. Some behaviours appear only in the bench's scenarios: the sampling latency set by the stage count, a complete rise-and-release sequence, a single request pulse that never raises ready, and the outputs continuing after a misuse event. Long random single-change walks compare every output against a model of the equations.

// File: rtl/hgr_pkg.sv
package hgr_pkg;

   // bit 1 = request a, bit 0 = request b
   typedef logic [1:0] req_pair_t;

   function automatic logic any_high(input req_pair_t p);
      return p[1] | p[0];
   endfunction

   function automatic logic both_high(input req_pair_t p);
      return p[1] & p[0];
   endfunction

   function automatic logic next_state(input req_pair_t p, input logic s);
      return (any_high(p) & s) | both_high(p);
   endfunction

   function automatic logic grant_of(input req_pair_t p, input logic s);
      return (any_high(p) & ~s) | both_high(p);
   endfunction

   function automatic logic ready_of(input req_pair_t p, input logic s);
      return s | both_high(p);
   endfunction

endpackage

// File: rtl/hgr_sampler.sv
module hgr_sampler
   import hgr_pkg::*;
#(
   parameter int STAGES = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  req_pair_t din,
   output req_pair_t nxt,
   output req_pair_t samp
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 1) begin : g_bad_depth
      $error("hgr_sampler: STAGES must be at least 1");
   end

   req_pair_t stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   if (STAGES == 1) begin : g_single
      assign nxt = din;
   end else begin : g_chain
      assign nxt = stg[LAST-1];
   end

   assign samp = stg[LAST];

endmodule

// File: rtl/hgr_logic.sv
module hgr_logic
   import hgr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  req_pair_t samp,
   output logic      grant,
   output logic      ready
);

   logic state_q;
   logic state_d;

   always_comb state_d = next_state(samp, state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= 1'b0;
      else        state_q <= state_d;
   end

   always_comb begin
      grant = grant_of(samp, state_q);
      ready = ready_of(samp, state_q);
   end

endmodule

// File: rtl/hgr_misuse.sv
module hgr_misuse
   import hgr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  req_pair_t nxt,
   input  req_pair_t samp,
   output logic      err
);

   logic dbl_change;

   always_comb dbl_change = &(nxt ^ samp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          err <= 1'b0;
      else if (dbl_change) err <= 1'b1;
   end

endmodule

// File: rtl/hgr_ctrl.sv
module hgr_ctrl
   import hgr_pkg::*;
#(
   parameter int IN_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_a,
   input  logic req_b,
   output logic grant,
   output logic ready,
   output logic proto_err
);

   req_pair_t raw_w;
   req_pair_t nxt_w;
   req_pair_t samp_w;

   assign raw_w = {req_a, req_b};

   hgr_sampler #(.STAGES(IN_STAGES)) u_sampler (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_w),
      .nxt  (nxt_w),
      .samp (samp_w)
   );

   hgr_logic u_logic (
      .clk  (clk),
      .rst_n(rst_n),
      .samp (samp_w),
      .grant(grant),
      .ready(ready)
   );

   hgr_misuse u_misuse (
      .clk  (clk),
      .rst_n(rst_n),
      .nxt  (nxt_w),
      .samp (samp_w),
      .err  (proto_err)
   );

endmodule

// File: rtl/hgr_ctrl_chk.sv
module hgr_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] samp,
   input logic [1:0] nxt,
   input logic       grant,
   input logic       ready,
   input logic       proto_err
);

   assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(samp) == 2'b00 && $countones(samp) == 1) |-> (grant && !ready));

   assert_both_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (samp == 2'b11) |-> (grant && ready));

   assert_first_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(samp) == 2'b11 && $countones(samp) == 1) |-> (!grant && ready));

   assert_ready_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(samp) == 2'b00 && samp == 2'b00) |-> (!ready && !grant));

   assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (&(nxt ^ samp)) |=> proto_err);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

endmodule

bind hgr_ctrl hgr_ctrl_chk u_hgr_ctrl_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .samp     (samp_w),
   .nxt      (nxt_w),
   .grant    (grant),
   .ready    (ready),
   .proto_err(proto_err)
);

// File: tb/test_hgr_ctrl.sv
module test_hgr_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int STG        = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_a = 1'b0;
   logic req_b = 1'b0;
   logic grant, ready, proto_err;

   int n_tests = 0;
   int n_fail  = 0;

   logic [1:0] m_stg [STG];
   logic       m_y;
   logic       m_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   hgr_ctrl #(.IN_STAGES(STG)) i_hgr_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_a    (req_a),
      .req_b    (req_b),
      .grant    (grant),
      .ready    (ready),
      .proto_err(proto_err)
   );

   function automatic logic exp_grant(input logic [1:0] p, input logic s);
      return ((p[1] | p[0]) & ~s) | (p[1] & p[0]);
   endfunction

   function automatic logic exp_ready(input logic [1:0] p, input logic s);
      return s | (p[1] & p[0]);
   endfunction

   function automatic logic exp_state(input logic [1:0] p, input logic s);
      return ((p[1] | p[0]) & s) | (p[1] & p[0]);
   endfunction

   task automatic chk(input string tag, input logic got, input logic exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < STG; i++) m_stg[i] = 2'b00;
      m_y = 1'b0;
      m_err = 1'b0;
   endtask

   task automatic model_edge(input logic [1:0] din);
      logic [1:0] entering;
      entering = (STG == 1) ? din : m_stg[STG-2];
      if (&(entering ^ m_stg[STG-1])) m_err = 1'b1;
      m_y = exp_state(m_stg[STG-1], m_y);
      for (int i = STG - 1; i > 0; i--) m_stg[i] = m_stg[i-1];
      m_stg[0] = din;
   endtask

   // drive at the falling edge, model at the rising edge, compare 1 time unit later
   task automatic step(input logic a, input logic b, input string tag);
      @(negedge clk);
      req_a = a;
      req_b = b;
      @(posedge clk);
      model_edge({a, b});
      #1;
      chk({tag, " grant"}, grant, exp_grant(m_stg[STG-1], m_y));
      chk({tag, " ready"}, ready, exp_ready(m_stg[STG-1], m_y));
      chk({tag, " proto_err"}, proto_err, m_err);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_a = 1'b0;
      req_b = 1'b0;
      model_reset();
      repeat (2) @(posedge clk);
      #1;
      chk("R1 grant in reset", grant, 1'b0);
      chk("R1 ready in reset", ready, 1'b0);
      chk("R1 proto_err in reset", proto_err, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, "R1 after release");
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : stimulus
      logic a_cur, b_cur;
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED_1234);
      model_reset();
      do_reset();

      // R2: latency of the sampling chain
      step(1'b1, 1'b0, "R2 first edge");
      chk("R2 grant still old sample", grant, 1'b0);
      step(1'b1, 1'b0, "R3 rise a");
      chk("R3 grant on single rise", grant, 1'b1);
      chk("R3 ready low on single rise", ready, 1'b0);

      step(1'b1, 1'b1, "R4 b joins");
      step(1'b1, 1'b1, "R4 both high");
      chk("R4 grant both high", grant, 1'b1);
      chk("R4 ready both high", ready, 1'b1);
      step(1'b1, 1'b1, "R8 settle");

      step(1'b0, 1'b1, "R5 a drops");
      step(1'b0, 1'b1, "R5 a dropped");
      chk("R5 grant after first drop", grant, 1'b0);
      chk("R5 ready after first drop", ready, 1'b1);

      step(1'b0, 1'b0, "R6 b drops");
      step(1'b0, 1'b0, "R6 first idle sample");
      chk("R6 ready held on first idle sample", ready, 1'b1);
      step(1'b0, 1'b0, "R6 second idle sample");
      chk("R6 ready released", ready, 1'b0);
      chk("R6 grant low when idle", grant, 1'b0);

      // R7: lone pulse on b
      step(1'b0, 1'b1, "R7 b up");
      step(1'b0, 1'b1, "R7 b up sampled");
      chk("R7 grant pulse", grant, 1'b1);
      chk("R7 ready stays low", ready, 1'b0);
      step(1'b0, 1'b0, "R7 b down");
      step(1'b0, 1'b0, "R7 b down sampled");
      chk("R7 grant back low", grant, 1'b0);
      chk("R7 ready never rose", ready, 1'b0);

      // R9 / R10: both change at once
      step(1'b1, 1'b1, "R9 double rise");
      chk("R9 not yet flagged", proto_err, 1'b0);
      step(1'b1, 1'b1, "R9 double rise sampled");
      chk("R9 flag set", proto_err, 1'b1);
      chk("R10 grant follows equations", grant, 1'b1);
      chk("R10 ready follows equations", ready, 1'b1);
      step(1'b1, 1'b0, "R10 b drops");
      step(1'b1, 1'b0, "R10 b dropped");
      chk("R10 grant after drop with flag", grant, 1'b0);
      chk("R9 flag sticky", proto_err, 1'b1);
      step(1'b0, 1'b0, "R9 hold");
      step(1'b0, 1'b0, "R9 hold");
      chk("R9 flag still sticky", proto_err, 1'b1);

      do_reset();
      chk("R1 flag cleared by reset", proto_err, 1'b0);

      // random single-change walks with rare double changes
      a_cur = 1'b0;
      b_cur = 1'b0;
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 40) begin
         end else if (r < 70) a_cur = ~a_cur;
         else if (r < 99) b_cur = ~b_cur;
         else begin
            a_cur = ~a_cur;
            b_cur = ~b_cur;
         end
         step(a_cur, b_cur, "R8 random");
         if (n % 700 == 699) begin
            do_reset();
            a_cur = 1'b0;
            b_cur = 1'b0;
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule